// File: doc/BRIEF.md
# Burst Address Sequencer for a Pipelined Bus Master

This block is the address-generation half of a bus master on a pipelined on-chip bus. A local client hands it one command at a time: a start address, a beat size, a burst kind and a direction. The block turns that command into a train of address phases, one per beat. Each address phase overlaps the data phase of the beat before it. The block marks the first beat of a burst differently from the ones that follow, and drives an idle code whenever it has nothing to issue.

Incrementing bursts step the address by the beat size. Wrapping bursts keep every address inside an aligned window whose size is the beat size multiplied by the beat count, folding back to the window's base when the top is passed. A slave-side ready input stretches both pipeline stages together. Write data is pulled from the client one beat at a time and then held on the bus until the slave completes the beat. Read data is handed back to the client with a valid strobe. An error response from the slave ends the burst in progress and discards the beats that have not yet been issued.

Top module: `burst_seq`

## Requirements
- R1: `cmd_ready` is high exactly when no burst is being issued (and it is high out of reset). A command presented with `cmd_valid` on a clock edge where `cmd_ready` is high is accepted. Its first address phase appears in the very next cycle.
- R2: Burst kind codes on `cmd_burst`: 0 is a single beat; 1 is also treated as a single beat; 3, 5 and 7 are incrementing bursts of 4, 8 and 16 beats. Each incrementing beat address is the previous one plus 2^`cmd_size` bytes.
- R3: Codes 2, 4 and 6 are wrapping bursts of 4, 8 and 16 beats. Their addresses step by 2^`cmd_size` but stay inside the aligned window of beats×2^`cmd_size` bytes that holds the start address, folding back to the window base.
- R4: `bus_trans` is 0 (idle) when no address phase is pending, 2 on the first beat of a burst and 3 on every later beat.
- R5: Address, direction, size and burst-kind outputs change only on a clock edge where `bus_ready` is high. A pending address phase holds them steady while `bus_ready` is low.
- R6: For a write beat, `wr_pull` is high in the cycle whose closing edge accepts that beat's address phase. `wr_data` is captured on that edge into `bus_wdata`, which then stays unchanged through every wait cycle of the data phase.
- R7: For a read beat, `rd_valid` is high in the data-phase cycle where `bus_ready` is high and `bus_err` is low. In that cycle `rd_data` equals `bus_rdata`.
- R8: When `bus_ready` and `bus_err` are both high in the data phase of a beat that is not the last of its burst, the burst ends. The address phase on the bus at that edge is discarded, `bus_trans` is idle in the next cycle, no further beats of that burst are issued, and `rd_valid` stays low for the failed beat.
- R9: While `rst_n` is low, `bus_trans` is idle, `rd_valid` and `wr_pull` are low, and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| cmd_valid | input | 1 | Client presents a burst command |
| cmd_ready | output | 1 | Sequencer can take a command |
| cmd_addr | input | AW | Start byte address, aligned to the beat size |
| cmd_size | input | 3 | Beat size as log2 of the byte count |
| cmd_burst | input | 3 | Burst kind code (see R2, R3) |
| cmd_write | input | 1 | 1 for a write burst, 0 for a read burst |
| wr_data | input | DW | Write data for the beat being pulled |
| wr_pull | output | 1 | Write data for a beat is taken on this cycle's closing edge |
| rd_valid | output | 1 | A read beat completes in this cycle |
| rd_data | output | DW | Read data returned to the client |
| bus_addr | output | AW | Address of the pending address phase |
| bus_trans | output | 2 | Transfer code: 0 idle, 2 first beat, 3 later beat |
| bus_write | output | 1 | Direction of the pending address phase |
| bus_size | output | 3 | Beat size of the pending address phase |
| bus_burst | output | 3 | Burst kind of the pending address phase |
| bus_wdata | output | DW | Write data of the current data phase |
| bus_ready | input | 1 | Slave completes the current phase on this edge |
| bus_err | input | 1 | Slave reports an error for the current data phase |
| bus_rdata | input | DW | Read data from the slave |

## Verification
The hardest situation to reach is an error response that lands in the middle of a burst. At that moment the next beat's address phase is already on the bus and must be thrown away. The bench gets there by forcing `bus_ready` high, starting an eight-beat wrapping read, and watching for the first `rd_valid`. It raises `bus_err` in the following cycle, which is the data phase of the second beat, while the third address is pending. Folding of wrapping addresses from unaligned starts, and write data held through random wait states, are reached with fixed bursts and then a long run of random back-to-back commands under a random ready pattern.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  localparam int BEAT_W = 5;

  localparam logic [1:0] TR_IDLE  = 2'b00;
  localparam logic [1:0] TR_FIRST = 2'b10;
  localparam logic [1:0] TR_NEXT  = 2'b11;

  function automatic logic [BEAT_W-1:0] beat_count(input logic [2:0] code);
    logic [BEAT_W-1:0] n;
    case (code)
      3'd2, 3'd3: n = BEAT_W'(4);
      3'd4, 3'd5: n = BEAT_W'(8);
      3'd6, 3'd7: n = BEAT_W'(16);
      default:    n = BEAT_W'(1);
    endcase
    return n;
  endfunction

  function automatic logic is_wrapping(input logic [2:0] code);
    return (code == 3'd2) || (code == 3'd4) || (code == 3'd6);
  endfunction

endpackage

// File: rtl/bsq_addr_gen.sv
module bsq_addr_gen #(
  parameter int AW = 32,
  parameter int BW = 5
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [2:0]    size,
  input  logic [BW-1:0] beats,
  input  logic          wrap,
  output logic [AW-1:0] nxt_addr
);

  logic [AW-1:0] step;
  logic [AW-1:0] span_mask;
  logic [AW-1:0] inc;

  always_comb begin
    step      = AW'(1) << size;
    span_mask = (AW'(beats) << size) - AW'(1);
    inc       = cur_addr + step;
    if (wrap) begin
      nxt_addr = (cur_addr & ~span_mask) | (inc & span_mask);
    end else begin
      nxt_addr = inc;
    end
  end

endmodule

// File: rtl/bsq_beat_ctrl.sv
module bsq_beat_ctrl
  import bsq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  input  logic [2:0]    cmd_size,
  input  logic [2:0]    cmd_burst,
  input  logic          cmd_write,
  input  logic          adv,
  input  logic          kill,
  output logic          busy,
  output logic          first,
  output logic          last,
  output logic [AW-1:0] addr,
  output logic [2:0]    size,
  output logic [2:0]    burst,
  output logic          write
);

  logic              busy_q, busy_n;
  logic              first_q, first_n;
  logic [BEAT_W-1:0] left_q, left_n;
  logic [AW-1:0]     addr_q, addr_n;
  logic [2:0]        size_q, size_n;
  logic [2:0]        burst_q, burst_n;
  logic              write_q, write_n;
  logic [AW-1:0]     step_addr;
  logic              load_en;

  bsq_addr_gen #(.AW(AW), .BW(BEAT_W)) u_gen (
    .cur_addr (addr_q),
    .size     (size_q),
    .beats    (beat_count(burst_q)),
    .wrap     (is_wrapping(burst_q)),
    .nxt_addr (step_addr)
  );

  assign load_en = cmd_valid && !busy_q;

  always_comb begin
    busy_n  = busy_q;
    first_n = first_q;
    left_n  = left_q;
    addr_n  = addr_q;
    size_n  = size_q;
    burst_n = burst_q;
    write_n = write_q;
    if (busy_q && adv) begin
      if (kill || (left_q == BEAT_W'(1))) begin
        busy_n = 1'b0;
      end else begin
        addr_n  = step_addr;
        left_n  = left_q - BEAT_W'(1);
        first_n = 1'b0;
      end
    end
    if (load_en) begin
      busy_n  = 1'b1;
      first_n = 1'b1;
      left_n  = beat_count(cmd_burst);
      addr_n  = cmd_addr;
      size_n  = cmd_size;
      burst_n = cmd_burst;
      write_n = cmd_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      left_q  <= '0;
      addr_q  <= '0;
      size_q  <= '0;
      burst_q <= '0;
      write_q <= 1'b0;
    end else begin
      busy_q  <= busy_n;
      first_q <= first_n;
      left_q  <= left_n;
      addr_q  <= addr_n;
      size_q  <= size_n;
      burst_q <= burst_n;
      write_q <= write_n;
    end
  end

  assign busy  = busy_q;
  assign first = first_q;
  assign last  = (left_q == BEAT_W'(1));
  assign addr  = addr_q;
  assign size  = size_q;
  assign burst = burst_q;
  assign write = write_q;

  // R5: a pending address phase is frozen while the slave stalls
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !adv) |=> (busy_q && $stable(addr_q) && $stable(first_q)
                          && $stable(write_q) && $stable(burst_q)));

endmodule

// File: rtl/bsq_data_pipe.sv
module bsq_data_pipe #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          busy,
  input  logic          write,
  input  logic          last,
  input  logic          bus_err,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] bus_rdata,
  output logic          kill,
  output logic          wr_pull,
  output logic [DW-1:0] wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  logic          dpv_q, dpv_n;
  logic          dpw_q, dpw_n;
  logic          dpl_q, dpl_n;
  logic [DW-1:0] wdata_q, wdata_n;

  assign kill    = adv && dpv_q && bus_err && !dpl_q;
  assign wr_pull = adv && busy && write && !kill;

  always_comb begin
    dpv_n   = dpv_q;
    dpw_n   = dpw_q;
    dpl_n   = dpl_q;
    wdata_n = wdata_q;
    if (adv) begin
      dpv_n = busy && !kill;
      dpw_n = write;
      dpl_n = last;
    end
    if (wr_pull) begin
      wdata_n = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dpv_q   <= 1'b0;
      dpw_q   <= 1'b0;
      dpl_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      dpv_q   <= dpv_n;
      dpw_q   <= dpw_n;
      dpl_q   <= dpl_n;
      wdata_q <= wdata_n;
    end
  end

  assign wdata    = wdata_q;
  assign rd_valid = dpv_q && !dpw_q && adv && !bus_err;
  assign rd_data  = bus_rdata;

  // R6: write data is held through data-phase wait states
  assert_wdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dpv_q && dpw_q && !adv) |=> $stable(wdata_q));

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import bsq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [2:0]    cmd_size,
  input  logic [2:0]    cmd_burst,
  input  logic          cmd_write,
  input  logic [DW-1:0] wr_data,
  output logic          wr_pull,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_trans,
  output logic          bus_write,
  output logic [2:0]    bus_size,
  output logic [2:0]    bus_burst,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic          bus_err,
  input  logic [DW-1:0] bus_rdata
);

  logic busy;
  logic first;
  logic last;
  logic kill;

  bsq_beat_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_size  (cmd_size),
    .cmd_burst (cmd_burst),
    .cmd_write (cmd_write),
    .adv       (bus_ready),
    .kill      (kill),
    .busy      (busy),
    .first     (first),
    .last      (last),
    .addr      (bus_addr),
    .size      (bus_size),
    .burst     (bus_burst),
    .write     (bus_write)
  );

  bsq_data_pipe #(.DW(DW)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (bus_ready),
    .busy      (busy),
    .write     (bus_write),
    .last      (last),
    .bus_err   (bus_err),
    .wr_data   (wr_data),
    .bus_rdata (bus_rdata),
    .kill      (kill),
    .wr_pull   (wr_pull),
    .wdata     (bus_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  assign cmd_ready = !busy;

  always_comb begin
    if (!busy) begin
      bus_trans = TR_IDLE;
    end else if (first) begin
      bus_trans = TR_FIRST;
    end else begin
      bus_trans = TR_NEXT;
    end
  end

  // R1: an accepted command shows its first beat in the next cycle
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (bus_trans == TR_FIRST));

  // R4: a later-beat code never follows an idle cycle
  assert_seq_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == TR_NEXT) |-> ($past(bus_trans) != TR_IDLE));

  // R8: an error mid-burst leaves the address bus idle next cycle
  assert_err_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (bus_trans == TR_IDLE));

endmodule

// File: tb/burst_seq_test.sv
module burst_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr;
  logic [2:0]    cmd_size;
  logic [2:0]    cmd_burst;
  logic          cmd_write;
  logic [DW-1:0] wr_data;
  logic          wr_pull;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_trans;
  logic          bus_write;
  logic [2:0]    bus_size;
  logic [2:0]    bus_burst;
  logic [DW-1:0] bus_wdata;
  logic          bus_ready;
  logic          bus_err;
  logic [DW-1:0] bus_rdata;

  burst_seq #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_size(cmd_size), .cmd_burst(cmd_burst), .cmd_write(cmd_write),
    .wr_data(wr_data), .wr_pull(wr_pull), .rd_valid(rd_valid), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_trans(bus_trans), .bus_write(bus_write),
    .bus_size(bus_size), .bus_burst(bus_burst), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_busy;
  int          m_k, m_n;
  bit          m_wrap, m_write;
  int          m_size;
  logic [2:0]  m_code;
  logic [31:0] m_start;
  bit          m_dpv, m_dpw, m_dplast;
  logic [31:0] m_wdata;

  function automatic logic [31:0] model_addr();
    int unsigned step, total, off, base;
    step = 1 << m_size;
    if (m_wrap) begin
      total = m_n * step;
      off   = m_start % total;
      base  = m_start - off;
      return base + ((off + m_k * step) % total);
    end
    return m_start + m_k * step;
  endfunction

  function automatic bit model_kill();
    return bus_ready && bus_err && m_dpv && !m_dplast;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_k = 0; m_n = 1; m_wrap = 0; m_write = 0; m_size = 0;
      m_code = 0; m_start = 0; m_dpv = 0; m_dpw = 0; m_dplast = 0; m_wdata = 0;
    end else begin
      bit was_busy, kl, nv, nw, nl;
      was_busy = m_busy;
      if (bus_ready) begin
        kl = model_kill();
        nv = m_busy && !kl;
        nw = m_write;
        nl = (m_k == m_n - 1);
        if (m_busy && m_write && !kl) m_wdata = wr_data;
        if (m_busy) begin
          if (kl || m_k == m_n - 1) m_busy = 0;
          else m_k++;
        end
        m_dpv = nv; m_dpw = nw; m_dplast = nl;
      end
      if (!was_busy && cmd_valid) begin
        m_busy  = 1;
        m_k     = 0;
        m_code  = cmd_burst;
        m_n     = (cmd_burst >= 6) ? 16 : (cmd_burst >= 4) ? 8 : (cmd_burst >= 2) ? 4 : 1;
        m_wrap  = (cmd_burst == 2) || (cmd_burst == 4) || (cmd_burst == 6);
        m_size  = cmd_size;
        m_start = cmd_addr;
        m_write = cmd_write;
      end
    end
  end

  // ---------------- slave-side driver ----------------
  bit ready_rand = 1'b1;
  bit err_arm    = 1'b0;
  bit err_done   = 1'b0;
  bit pull_prev  = 1'b0;
  bit mon_on     = 1'b0;
  int rd_seen    = 0;
  int wcnt       = 0;
  logic [31:0] acc_q[$];

  always @(negedge clk) begin
    if (pull_prev) wcnt++;
    wr_data   = 32'hA500_0000 + wcnt;
    bus_rdata = $urandom;
    if (err_arm) begin
      bus_ready = 1'b1;
      bus_err   = (rd_seen > 0) && !err_done;
      if (bus_err) err_done = 1'b1;
    end else begin
      bus_err   = 1'b0;
      bus_ready = ready_rand ? (($urandom % 4) != 0) : 1'b1;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    #1;
    if (rst_n && mon_on) begin
      logic [1:0] exp_tr;
      bit exp_rv, exp_pull;
      check(cmd_ready == !m_busy, "R1", "cmd_ready", 32'(cmd_ready), 32'(!m_busy));
      exp_tr = !m_busy ? 2'd0 : (m_k == 0 ? 2'd2 : 2'd3);
      check(bus_trans == exp_tr, "R4", "transfer code", 32'(bus_trans), 32'(exp_tr));
      if (m_busy) begin
        check(bus_addr == model_addr(), "R2/R3/R5", "address", bus_addr, model_addr());
        check(bus_write == m_write, "R5", "direction", 32'(bus_write), 32'(m_write));
        check(bus_size == 3'(m_size), "R5", "size", 32'(bus_size), 32'(m_size));
        check(bus_burst == m_code, "R5", "burst kind", 32'(bus_burst), 32'(m_code));
      end
      exp_rv = m_dpv && !m_dpw && bus_ready && !bus_err;
      check(rd_valid == exp_rv, "R7", "rd_valid", 32'(rd_valid), 32'(exp_rv));
      if (exp_rv) check(rd_data == bus_rdata, "R7", "rd_data", rd_data, bus_rdata);
      exp_pull = m_busy && m_write && bus_ready && !model_kill();
      check(wr_pull == exp_pull, "R6", "wr_pull", 32'(wr_pull), 32'(exp_pull));
      if (m_dpv && m_dpw) check(bus_wdata == m_wdata, "R6", "write data", bus_wdata, m_wdata);
    end
    pull_prev = wr_pull;
    if (rd_valid) rd_seen++;
    if (bus_trans != 2'd0 && bus_ready) acc_q.push_back(bus_addr);
  end

  // ---------------- helpers ----------------
  task automatic issue(input logic [31:0] a, input int s, input int b, input bit w);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_size = 3'(s); cmd_burst = 3'(b); cmd_write = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    repeat (2) @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_addrs(input string req, input logic [31:0] exp[$]);
    check(acc_q.size() == exp.size(), req, "beat count", 32'(acc_q.size()), 32'(exp.size()));
    foreach (exp[i]) begin
      if (i < acc_q.size())
        check(acc_q[i] == exp[i], req, "beat address", acc_q[i], exp[i]);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  // ---------------- test sequence ----------------
  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_size = '0;
    cmd_burst = '0; cmd_write = 1'b0; wr_data = '0;
    bus_ready = 1'b1; bus_err = 1'b0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    #1;
    // R9: reset state
    check(cmd_ready == 1'b1, "R9", "reset cmd_ready", 32'(cmd_ready), 32'd1);
    check(bus_trans == 2'd0, "R9", "reset transfer code", 32'(bus_trans), 32'd0);
    check(rd_valid == 1'b0, "R9", "reset rd_valid", 32'(rd_valid), 32'd0);
    check(wr_pull == 1'b0, "R9", "reset wr_pull", 32'(wr_pull), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R1 R7: single read
    acc_q.delete();
    issue(32'h100, 2, 0, 1'b0);
    wait_done();
    expect_addrs("R1", '{32'h100});

    // R2 R6: incrementing four-beat write
    acc_q.delete();
    issue(32'h200, 2, 3, 1'b1);
    wait_done();
    expect_addrs("R2", '{32'h200, 32'h204, 32'h208, 32'h20C});

    // R3: wrapping four-beat read from an unaligned start
    acc_q.delete();
    issue(32'h38, 2, 2, 1'b0);
    wait_done();
    expect_addrs("R3", '{32'h38, 32'h3C, 32'h30, 32'h34});

    // R3 R6: wrapping eight-beat halfword write
    acc_q.delete();
    issue(32'h1006, 1, 4, 1'b1);
    wait_done();
    expect_addrs("R3", '{32'h1006, 32'h1008, 32'h100A, 32'h100C,
                         32'h100E, 32'h1000, 32'h1002, 32'h1004});

    // R2: code 1 is a single beat
    acc_q.delete();
    issue(32'h300, 0, 1, 1'b0);
    wait_done();
    expect_addrs("R2", '{32'h300});

    // R2 R3: sixteen-beat byte bursts, back to back
    issue(32'h40, 0, 7, 1'b0);
    issue(32'h7B, 0, 6, 1'b1);
    wait_done();

    // R8: error in the second beat of a wrapping read
    ready_rand = 1'b0;
    repeat (2) @(negedge clk);
    rd_seen = 0; err_done = 1'b0; err_arm = 1'b1;
    issue(32'h50C, 2, 4, 1'b0);
    wait_done();
    check(rd_seen == 1, "R8", "read beats before error", 32'(rd_seen), 32'd1);
    check(err_done == 1'b1, "R8", "error injected", 32'(err_done), 32'd1);
    err_arm = 1'b0;
    ready_rand = 1'b1;
    // R8: the sequencer takes a fresh command after the error
    acc_q.delete();
    issue(32'h600, 2, 3, 1'b1);
    wait_done();
    expect_addrs("R8", '{32'h600, 32'h604, 32'h608, 32'h60C});

    // R5: long random run under random wait states
    for (int i = 0; i < 60; i++) begin
      int s;
      logic [31:0] a;
      s = $urandom % 3;
      a = ($urandom & 32'hFFFF) & ~((32'd1 << s) - 32'd1);
      issue(a, s, $urandom % 8, 1'($urandom % 2));
    end
    wait_done();

    finish_run();
  end

endmodule